// File: doc/BRIEF.md
# Noise-Tolerant Multiplier with Replica Check

This block multiplies two 12-bit unsigned operands and guards the full 24-bit product with a second, much smaller multiplier. The second multiplier works only on the upper half of each operand. Its short critical path keeps its result trustworthy even when the full-precision path is run faster than its own delay allows and returns wrong bits. The short result covers only the top six product bits. It is compared against the full product. When the two differ by more than a programmable bound, the block sends out the short result in place of the full one and raises a flag. The wrong full product is never recomputed.

The bound is loaded on `thresh`. For error-free operation it should equal the largest gap that can ever occur between an exact product and the short estimate. That gap comes from truncation alone, so any larger gap means the full-precision path has failed. The full-precision path cannot be made to fail by real timing here. Instead, a `fault_mask` input is XORed into the full product before the comparison. A bench can then stand in for timing faults of any size.

Operands, bound and mask are captured together in one register stage. The chosen value and the flag are captured in a second stage. Results follow their inputs at a fixed distance, and one sample can enter every cycle.

Top module: `guarded_mult`

## Requirements
- R1: While `rst_n` is low, and after it has been released until the first sample arrives, `out_valid`, `corrected` and `product` are all zero.
- R2: A sample taken with `in_valid` high at rising edge k shows on the outputs, with `out_valid` high, after rising edge k+1. Samples presented on consecutive edges come out on consecutive cycles.
- R3: With `fault_mask` zero and `thresh` at the worst-case truncation gap, `product` equals `op_a * op_b` exactly and `corrected` is low.
- R4: The estimate is the product of `op_a[11:6]` and `op_b[11:6]`, keeping bits 11:6 of that 12-bit result, placed at bits 23:18 with bits 17:0 zero.
- R5: The full product XOR `fault_mask` is the checked value. If its absolute distance from the estimate is larger than `thresh`, `product` is the estimate and `corrected` is high. Otherwise `product` is the checked value and `corrected` is low.
- R6: A distance exactly equal to `thresh` passes the checked value through. A distance one larger selects the estimate.
- R7: `thresh` and `fault_mask` are captured with their operands. Changing them after the capturing edge does not alter that sample's result.
- R8: `corrected` is never high while `out_valid` is low. A cycle without an input sample yields `out_valid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a sample on the operand inputs |
| op_a | input | 12 | First unsigned operand |
| op_b | input | 12 | Second unsigned operand |
| thresh | input | 24 | Largest tolerated distance between checked product and estimate |
| fault_mask | input | 24 | Bits flipped in the full product to emulate timing faults |
| out_valid | output | 1 | Marks a result on `product` |
| product | output | 24 | Selected result |
| corrected | output | 1 | High when `product` carries the estimate |

## Verification
The bench loads the worst-case gap, which it works out itself from the truncation arithmetic. It then checks that fault-free products, including all-ones operands where the gap peaks, are never replaced. A wrong estimate alignment or wrong operand slice would instead trigger spurious corrections. The bench sets the distance exactly at, and one above, the bound to catch a strict-versus-loose comparison. It uses single-bit faults both far above and at the bound to show that large errors are masked and tiny ones pass. It also changes the bound and mask just after capture, which exposes a design that reads them live instead of latching them with the operands.

// File: rtl/guard_pkg.sv
package guard_pkg;
    typedef enum logic {
        PICK_MAIN    = 1'b0,
        PICK_REPLICA = 1'b1
    } pick_e;
endpackage

// File: rtl/full_mult.sv
module full_mult #(
    parameter int OP_W = 12
) (
    input  logic [OP_W-1:0]   mul_a,
    input  logic [OP_W-1:0]   mul_b,
    output logic [2*OP_W-1:0] mul_p
);
    localparam int PW = 2 * OP_W;

    logic [PW-1:0] rows [OP_W];

    for (genvar r = 0; r < OP_W; r++) begin : g_row
        assign rows[r] = mul_b[r] ? (PW'(mul_a) << r) : '0;
    end

    always_comb begin
        mul_p = '0;
        for (int r = 0; r < OP_W; r++) begin
            mul_p = mul_p + rows[r];
        end
    end
endmodule

// File: rtl/trunc_replica.sv
module trunc_replica #(
    parameter int OP_W  = 12,
    parameter int REP_W = 6
) (
    input  logic [OP_W-1:0]   rep_a,
    input  logic [OP_W-1:0]   rep_b,
    output logic [2*OP_W-1:0] rep_p
);
    localparam int PW    = 2 * OP_W;
    localparam int SP_W  = 2 * REP_W;
    localparam int SHIFT = PW - REP_W;

    logic [REP_W-1:0] hi_a, hi_b;
    logic [SP_W-1:0]  short_p;
    logic [REP_W-1:0] kept;

    assign hi_a = rep_a[OP_W-1 -: REP_W];
    assign hi_b = rep_b[OP_W-1 -: REP_W];

    full_mult #(.OP_W(REP_W)) u_small (
        .mul_a (hi_a),
        .mul_b (hi_b),
        .mul_p (short_p)
    );

    assign kept  = short_p[SP_W-1 -: REP_W];
    assign rep_p = {kept, {SHIFT{1'b0}}};
endmodule

// File: rtl/mismatch_select.sv
module mismatch_select
    import guard_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic [PW-1:0] main_v,
    input  logic [PW-1:0] est_v,
    input  logic [PW-1:0] bound,
    output logic [PW-1:0] gap,
    output pick_e         pick,
    output logic [PW-1:0] chosen
);
    always_comb begin
        gap    = (main_v >= est_v) ? (main_v - est_v) : (est_v - main_v);
        pick   = (gap > bound) ? PICK_REPLICA : PICK_MAIN;
        chosen = (pick == PICK_REPLICA) ? est_v : main_v;
    end
endmodule

// File: rtl/guarded_mult.sv
module guarded_mult
    import guard_pkg::*;
#(
    parameter int OP_W  = 12,
    parameter int REP_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [OP_W-1:0]      op_a,
    input  logic [OP_W-1:0]      op_b,
    input  logic [2*OP_W-1:0]    thresh,
    input  logic [2*OP_W-1:0]    fault_mask,
    output logic                 out_valid,
    output logic [2*OP_W-1:0]    product,
    output logic                 corrected
);
    localparam int PW    = 2 * OP_W;
    localparam int SHIFT = PW - REP_W;

    typedef struct packed {
        logic            vld;
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic [PW-1:0]   th;
        logic [PW-1:0]   msk;
    } cap_t;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] res;
        logic          fix;
    } out_t;

    cap_t cap_d, cap_q;
    out_t out_d, out_q;

    logic [PW-1:0] exact_p, faulty_p, est_p, gap_v, pick_v;
    pick_e         pick_s;

    full_mult #(.OP_W(OP_W)) u_main (
        .mul_a (cap_q.a),
        .mul_b (cap_q.b),
        .mul_p (exact_p)
    );

    trunc_replica #(.OP_W(OP_W), .REP_W(REP_W)) u_rep (
        .rep_a (cap_q.a),
        .rep_b (cap_q.b),
        .rep_p (est_p)
    );

    assign faulty_p = exact_p ^ cap_q.msk;

    mismatch_select #(.PW(PW)) u_sel (
        .main_v (faulty_p),
        .est_v  (est_p),
        .bound  (cap_q.th),
        .gap    (gap_v),
        .pick   (pick_s),
        .chosen (pick_v)
    );

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = in_valid;
        if (in_valid) begin
            cap_d.a   = op_a;
            cap_d.b   = op_b;
            cap_d.th  = thresh;
            cap_d.msk = fault_mask;
        end
        out_d     = out_q;
        out_d.vld = cap_q.vld;
        out_d.fix = cap_q.vld && (pick_s == PICK_REPLICA);
        if (cap_q.vld) begin
            out_d.res = pick_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            out_q <= '0;
        end else begin
            cap_q <= cap_d;
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign product   = out_q.res;
    assign corrected = out_q.fix;

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> out_valid); // R2
    AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        corrected |-> out_valid); // R8
    AST_EST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && corrected) |-> (product[SHIFT-1:0] == '0)); // R4
    AST_PASS_CHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> (!corrected || (product == $past(est_p)))); // R5
    AST_KEEP_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> (corrected || (product == $past(faulty_p)))); // R5
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.vld && (gap_v <= cap_q.th)) |=> !corrected); // R6
endmodule

// File: tb/guarded_mult_test.sv
module guarded_mult_test;
    localparam int CLK_PERIOD = 10;
    localparam int OP_W = 12;
    localparam int PW = 24;
    localparam int WATCHDOG = 20000;

    typedef struct packed {
        logic [11:0] a;
        logic [11:0] b;
        logic [23:0] msk;
        logic [23:0] th;
        logic        use_max;
        logic        flag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{12'h000, 12'h000, 24'h000000, 24'h0,     1'b1, 1'b0},
        '{12'hFFF, 12'hFFF, 24'h000000, 24'h0,     1'b1, 1'b0},
        '{12'h040, 12'h040, 24'h000000, 24'h0,     1'b1, 1'b0},
        '{12'h040, 12'h040, 24'h100000, 24'h0,     1'b1, 1'b1},
        '{12'hABC, 12'h123, 24'h000000, 24'h0,     1'b1, 1'b0},
        '{12'hFFF, 12'hFFF, 24'h800000, 24'h0,     1'b1, 1'b1},
        '{12'h040, 12'h040, 24'h000000, 24'h0,     1'b0, 1'b1},
        '{12'h040, 12'h040, 24'h000000, 24'd4096,  1'b0, 1'b0},
        '{12'h040, 12'h040, 24'h000000, 24'd4095,  1'b0, 1'b1},
        '{12'h000, 12'h000, 24'h000001, 24'h0,     1'b0, 1'b1},
        '{12'h000, 12'h000, 24'h000001, 24'h1,     1'b0, 1'b0},
        '{12'h800, 12'h800, 24'h000000, 24'h0,     1'b0, 1'b0},
        '{12'hFC0, 12'hFC0, 24'h000000, 24'h0,     1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [OP_W-1:0] op_a = '0, op_b = '0;
    logic [PW-1:0] thresh = '0, fault_mask = '0;
    logic out_valid, corrected;
    logic [PW-1:0] product;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [PW-1:0] th_max;

    guarded_mult uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .thresh(thresh), .fault_mask(fault_mask),
        .out_valid(out_valid), .product(product), .corrected(corrected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=%0d", cyc, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Estimate per R4: top six bits of the product of the operand upper halves, at 23:18.
    function automatic logic [PW-1:0] estimate(input logic [11:0] a, input logic [11:0] b);
        logic [11:0] sp;
        sp = 12'(a[11:6] * b[11:6]);
        return {sp[11:6], 18'b0};
    endfunction

    // Selection per R5/R6; returns {flag, result}.
    function automatic logic [PW:0] expect_out(input logic [11:0] a, input logic [11:0] b,
                                               input logic [PW-1:0] m, input logic [PW-1:0] t);
        logic [PW-1:0] chk, est, d;
        chk = PW'(a * b) ^ m;
        est = estimate(a, b);
        d = (chk >= est) ? chk - est : est - chk;
        return (d > t) ? {1'b1, est} : {1'b0, chk};
    endfunction

    task automatic drive(input logic [11:0] a, input logic [11:0] b,
                         input logic [PW-1:0] m, input logic [PW-1:0] t);
        in_valid = 1'b1; op_a = a; op_b = b; fault_mask = m; thresh = t;
    endtask

    initial begin
        logic [PW:0] e;
        // Worst truncation gap: for fixed upper halves the gap grows with both lower halves,
        // so scanning upper halves with lower halves at all-ones covers every input.
        th_max = '0;
        for (int ha = 0; ha < 64; ha++) begin
            for (int hb = 0; hb < 64; hb++) begin
                logic [11:0] a, b;
                logic [PW-1:0] g;
                a = {6'(ha), 6'h3F};
                b = {6'(hb), 6'h3F};
                g = PW'(a * b) - estimate(a, b);
                if (g > th_max) th_max = g;
            end
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", PW'(out_valid), '0);
        check("R1 corrected in reset", PW'(corrected), '0);
        check("R1 product in reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", PW'(out_valid), '0);

        // Table walk: R3, R5, R6, R7 main selection cases
        for (int i = 0; i < NV; i++) begin
            logic [PW-1:0] t;
            t = VECS[i].use_max ? th_max : VECS[i].th;
            e = expect_out(VECS[i].a, VECS[i].b, VECS[i].msk, t);
            drive(VECS[i].a, VECS[i].b, VECS[i].msk, t);
            @(negedge clk);
            in_valid = 1'b0;
            check("R2 not yet valid after one edge", PW'(out_valid), '0);
            @(negedge clk);
            check("R2 valid after two edges", PW'(out_valid), 1);
            check("R5 product", product, e[PW-1:0]);
            check("R5 corrected", PW'(corrected), PW'(e[PW]));
            check("R6 table flag", PW'(corrected), PW'(VECS[i].flag));
        end

        // R3: exact product for fault-free all-ones operands
        drive(12'hFFF, 12'hFFF, '0, th_max);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R3 exact product", product, 24'd16769025);
        check("R3 no correction", PW'(corrected), '0);

        // R4: estimate alignment with zero threshold (gap 4096 forces estimate)
        drive(12'hFC0, 12'hFC0, '0, '0);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R4 aligned estimate", product, {6'd62, 18'b0});

        // R7: change bound and mask after capture edge
        drive(12'h040, 12'h040, '0, '0);
        @(negedge clk);
        in_valid = 1'b0; thresh = 24'hFFFFFF; fault_mask = 24'h000001;
        @(negedge clk);
        check("R7 captured bound kept", PW'(corrected), 1);
        check("R7 captured mask kept", product, '0);

        // R8: idle cycle yields no valid and no flag
        fault_mask = '0; thresh = '0;
        @(negedge clk);
        check("R8 idle out_valid", PW'(out_valid), '0);
        check("R8 idle corrected", PW'(corrected), '0);

        // R2: back-to-back samples on consecutive cycles
        drive(12'h003, 12'h005, '0, th_max);
        @(negedge clk);
        drive(12'h007, 12'h009, '0, th_max);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 first of pair", product, 24'd15);
        @(negedge clk);
        check("R2 second of pair", product, 24'd63);
        check("R2 second valid", PW'(out_valid), 1);
        @(negedge clk);
        check("R8 pair drained", PW'(out_valid), '0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule